// File: doc/BRIEF.md
# Power-State Phase and Telemetry Controller

This block turns committed power-state requests into per-channel operating modes for two multi-phase regulator rails: a three-channel core rail and a two-channel northbridge rail. Each rail has two active-low power-state levels, a primary and a secondary. Whenever the primary level is asserted, the rail sheds to one channel running in diode emulation. The secondary level cannot override the primary. The block also holds the telemetry mode, which is decoded from a telemetry-function bit and the two domain-select bits of the most recent command.

A command receiver presents the decoded bits and pulses a commit strobe for one cycle. Nothing changes between strobes, apart from the staged wake-up. When a rail leaves light load, channel 1 goes back to continuous-conduction mode (CCM) first. The higher channels follow one cycle later, so the phase-enable outputs never switch together.

Top module: `power_state_ctrl`

## Requirements
- R1: After synchronous reset, every channel mode is CCM (code 00), every enable is 1 and the telemetry mode is voltage-and-current (code 00).
- R2: A commit with the core primary level low (`core_ps0_n`=0) sets core channel 1 to diode emulation (code 01) and core channels 2 and 3 to tri-state (code 10) with enables 0, from the cycle after the strobe. Channel n occupies mode bits [2n-1:2n-2].
- R3: A commit with `nb_ps0_n`=0 sets northbridge channel 1 to diode emulation and channel 2 to tri-state, from the cycle after the strobe.
- R4: The secondary level never overrides the primary. With the primary asserted, the rail is in single-channel diode emulation whatever the secondary level. With the primary deasserted, the rail runs full CCM even when the secondary is asserted.
- R5: A commit that deasserts the primary level on a light-loaded rail puts channel 1 in CCM (enable 1) and keeps the higher channels tri-stated in the next cycle. One cycle later, all channels are in CCM with all enables set.
- R6: Without a commit strobe, changes on the level, telemetry and select inputs have no effect on any output.
- R7: A commit with telemetry-function=1, core-select=0, nb-select=1 selects voltage-and-current telemetry (code 00).
- R8: A commit with telemetry-function=1 and both selects 0 selects voltage-only telemetry (code 01).
- R9: A commit with telemetry-function=1, core-select=1, nb-select=0 disables telemetry (code 10).
- R10: A commit with telemetry-function=1 and both selects 1 (reserved) leaves the telemetry mode unchanged.
- R11: A commit with telemetry-function=0 leaves the telemetry mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | One-cycle strobe that applies the command inputs |
| core_ps0_n | input | 1 | Core primary power-state level, active low |
| core_ps1_n | input | 1 | Core secondary power-state level, active low |
| nb_ps0_n | input | 1 | Northbridge primary power-state level, active low |
| nb_ps1_n | input | 1 | Northbridge secondary power-state level, active low |
| cmd_tfn | input | 1 | Telemetry-function bit of the command |
| cmd_core_sel | input | 1 | Core domain-select bit |
| cmd_nb_sel | input | 1 | Northbridge domain-select bit |
| core_mode | output | 6 | Core channel modes, 2 bits per channel |
| core_en | output | 3 | Core phase enables, bit n-1 for channel n |
| nb_mode | output | 4 | Northbridge channel modes, 2 bits per channel |
| nb_en | output | 2 | Northbridge phase enables |
| telem_mode | output | 2 | Telemetry mode: 00 V+I, 01 V only, 10 off |

## Verification
A rail state register holding a wrong value shows on the mode and enable ports in the cycle after the commit that caused it. A stuck wake stage shows one cycle later still, because either channel 1 is never separated from the higher channels or the higher channels never come back. A wrong telemetry register is visible immediately after the strobe. A reserved or telemetry-function-0 command that corrupts the register shows only against the value held before that command, so the bench always checks those commands against a known, non-reset previous mode.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        CH_CCM = 2'b00,
        CH_DE  = 2'b01,
        CH_OFF = 2'b10
    } chan_mode_t;

    typedef enum logic [1:0] {
        TM_VOLT_CURR = 2'b00,
        TM_VOLT_ONLY = 2'b01,
        TM_DISABLED  = 2'b10
    } telem_mode_t;

    typedef enum logic [1:0] {
        RS_FULL  = 2'b00,
        RS_LIGHT = 2'b01,
        RS_WAKE  = 2'b10
    } rail_state_t;

    typedef enum logic [1:0] {
        PL_NORMAL  = 2'b00,
        PL_LVL1    = 2'b01,
        PL_LVL0    = 2'b10,
        PL_LVL0_1  = 2'b11
    } power_level_t;

    typedef struct packed {
        logic tfn;
        logic core_sel;
        logic nb_sel;
    } telem_cmd_t;

    localparam int CORE_CHANNELS = 3;
    localparam int NB_CHANNELS   = 2;

    // Collapse the two active-low levels into one request
    function automatic power_level_t decode_level(input logic ps0_n, input logic ps1_n);
        case ({ps0_n, ps1_n})
            2'b00:   return PL_LVL0_1;
            2'b01:   return PL_LVL0;
            2'b10:   return PL_LVL1;
            default: return PL_NORMAL;
        endcase
    endfunction

    // Primary level dominates: only it sheds phases
    function automatic logic wants_light(input power_level_t lvl);
        return (lvl == PL_LVL0) || (lvl == PL_LVL0_1);
    endfunction

endpackage

// File: rtl/psc_rail.sv
module psc_rail
    import psc_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  power_level_t          level,
    output logic [2*NUM_CH-1:0]   mode,
    output logic [NUM_CH-1:0]     en
);
    localparam logic [NUM_CH-1:0] ALL_EN = {NUM_CH{1'b1}};

    rail_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (commit) begin
            if (wants_light(level))
                state_d = RS_LIGHT;
            else if (state_q == RS_LIGHT)
                state_d = RS_WAKE;
            else
                state_d = RS_FULL;
        end else if (state_q == RS_WAKE) begin
            state_d = RS_FULL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RS_FULL;
        else     state_q <= state_d;
    end

    // Channel 1 never tri-states; it only toggles between CCM and DE
    always_comb begin
        mode[1:0] = (state_q == RS_LIGHT) ? CH_DE : CH_CCM;
        en[0]     = 1'b1;
    end

    generate
        for (genvar i = 1; i < NUM_CH; i++) begin : g_upper
            always_comb begin
                mode[2*i+1:2*i] = (state_q == RS_FULL) ? CH_CCM : CH_OFF;
                en[i]           = (state_q == RS_FULL);
            end
        end
    endgenerate

    assert_shed_R2_R3: assert property (@(posedge clk) disable iff (rst)
        (commit && wants_light(level)) |=> (mode[1:0] == CH_DE && en == 1));

    assert_secondary_only_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && level == PL_LVL1 && state_q != RS_LIGHT) |=> (en == ALL_EN));

    assert_wake_first_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && !wants_light(level) && state_q == RS_LIGHT)
            |=> (en == 1 && mode[1:0] == CH_CCM));

    assert_wake_rest_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_WAKE && !(commit && wants_light(level))) |=> (en == ALL_EN));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!commit && state_q != RS_WAKE) |=> $stable(mode));

endmodule

// File: rtl/psc_telem.sv
module psc_telem
    import psc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        commit,
    input  telem_cmd_t  cmd,
    output telem_mode_t tmode
);
    telem_mode_t tmode_d;

    always_comb begin
        tmode_d = tmode;
        if (commit && cmd.tfn) begin
            case ({cmd.core_sel, cmd.nb_sel})
                2'b01:   tmode_d = TM_VOLT_CURR;
                2'b00:   tmode_d = TM_VOLT_ONLY;
                2'b10:   tmode_d = TM_DISABLED;
                default: tmode_d = tmode;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmode <= TM_VOLT_CURR;
        else     tmode <= tmode_d;
    end

    assert_vi_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd == 3'b101) |=> (tmode == TM_VOLT_CURR));

    assert_v_R8: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd == 3'b100) |=> (tmode == TM_VOLT_ONLY));

    assert_off_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd == 3'b110) |=> (tmode == TM_DISABLED));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd == 3'b111) |=> $stable(tmode));

    assert_no_tfn_R11: assert property (@(posedge clk) disable iff (rst)
        (!commit || !cmd.tfn) |=> $stable(tmode));

endmodule

// File: rtl/power_state_ctrl.sv
module power_state_ctrl
    import psc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit,
    input  logic                      core_ps0_n,
    input  logic                      core_ps1_n,
    input  logic                      nb_ps0_n,
    input  logic                      nb_ps1_n,
    input  logic                      cmd_tfn,
    input  logic                      cmd_core_sel,
    input  logic                      cmd_nb_sel,
    output logic [2*CORE_CHANNELS-1:0] core_mode,
    output logic [CORE_CHANNELS-1:0]   core_en,
    output logic [2*NB_CHANNELS-1:0]   nb_mode,
    output logic [NB_CHANNELS-1:0]     nb_en,
    output logic [1:0]                 telem_mode
);
    power_level_t core_lvl, nb_lvl;
    telem_cmd_t   tcmd;
    telem_mode_t  tmode;

    assign core_lvl = decode_level(core_ps0_n, core_ps1_n);
    assign nb_lvl   = decode_level(nb_ps0_n, nb_ps1_n);
    assign tcmd     = '{tfn: cmd_tfn, core_sel: cmd_core_sel, nb_sel: cmd_nb_sel};

    psc_rail #(.NUM_CH(CORE_CHANNELS)) u_core (
        .clk(clk), .rst(rst), .commit(commit), .level(core_lvl),
        .mode(core_mode), .en(core_en)
    );

    psc_rail #(.NUM_CH(NB_CHANNELS)) u_nb (
        .clk(clk), .rst(rst), .commit(commit), .level(nb_lvl),
        .mode(nb_mode), .en(nb_en)
    );

    psc_telem u_telem (
        .clk(clk), .rst(rst), .commit(commit), .cmd(tcmd), .tmode(tmode)
    );

    assign telem_mode = tmode;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (core_en == 3'b111 && nb_en == 2'b11 && telem_mode == 2'b00));

endmodule

// File: tb/tb_power_state_ctrl.sv
module tb_power_state_ctrl;
    logic clk = 0, rst = 1, commit = 0;
    logic core_ps0_n = 1, core_ps1_n = 1, nb_ps0_n = 1, nb_ps1_n = 1;
    logic cmd_tfn = 0, cmd_core_sel = 0, cmd_nb_sel = 0;
    logic [5:0] core_mode;
    logic [2:0] core_en;
    logic [3:0] nb_mode;
    logic [1:0] nb_en;
    logic [1:0] telem_mode;
    int compared = 0, mismatched = 0;
    bit done = 0;

    localparam logic [5:0] CORE_FULL  = 6'b00_00_00;
    localparam logic [5:0] CORE_LIGHT = 6'b10_10_01;
    localparam logic [5:0] CORE_WAKE  = 6'b10_10_00;
    localparam logic [3:0] NB_FULL    = 4'b00_00;
    localparam logic [3:0] NB_LIGHT   = 4'b10_01;
    localparam logic [3:0] NB_WAKE    = 4'b10_00;

    always #5 clk = ~clk;

    power_state_ctrl dut (.*);

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send(input logic c0, input logic c1, input logic n0, input logic n1,
                        input logic t, input logic cs, input logic ns);
        @(negedge clk);
        core_ps0_n = c0; core_ps1_n = c1; nb_ps0_n = n0; nb_ps1_n = n1;
        cmd_tfn = t; cmd_core_sel = cs; cmd_nb_sel = ns;
        commit = 1;
        @(negedge clk);
        commit = 0;
    endtask

    task automatic t_reset_r1();
        check("R1 core_mode", {2'b0, core_mode}, {2'b0, CORE_FULL});
        check("R1 core_en", {5'b0, core_en}, 8'h07);
        check("R1 nb_mode", {4'b0, nb_mode}, {4'b0, NB_FULL});
        check("R1 nb_en", {6'b0, nb_en}, 8'h03);
        check("R1 telem", {6'b0, telem_mode}, 8'h00);
    endtask

    task automatic t_shed_r2_r3();
        send(0, 1, 1, 1, 0, 0, 0);
        check("R2 core light", {2'b0, core_mode}, {2'b0, CORE_LIGHT});
        check("R2 core en", {5'b0, core_en}, 8'h01);
        check("R3 nb untouched", {4'b0, nb_mode}, {4'b0, NB_FULL});
        send(0, 1, 0, 1, 0, 0, 0);
        check("R3 nb light", {4'b0, nb_mode}, {4'b0, NB_LIGHT});
        check("R3 nb en", {6'b0, nb_en}, 8'h01);
    endtask

    task automatic t_secondary_r4();
        send(0, 0, 0, 0, 0, 0, 0);
        check("R4 both asserted core", {2'b0, core_mode}, {2'b0, CORE_LIGHT});
        check("R4 both asserted nb", {4'b0, nb_mode}, {4'b0, NB_LIGHT});
        // primary released, secondary held: staged return to CCM
        send(1, 0, 1, 0, 0, 0, 0);
        check("R5 core wake stage", {2'b0, core_mode}, {2'b0, CORE_WAKE});
        check("R5 core wake en", {5'b0, core_en}, 8'h01);
        check("R5 nb wake stage", {4'b0, nb_mode}, {4'b0, NB_WAKE});
        check("R5 nb wake en", {6'b0, nb_en}, 8'h01);
        @(negedge clk);
        check("R4 core full with secondary", {2'b0, core_mode}, {2'b0, CORE_FULL});
        check("R5 core all en", {5'b0, core_en}, 8'h07);
        check("R5 nb all en", {6'b0, nb_en}, 8'h03);
        send(1, 0, 1, 0, 0, 0, 0);
        check("R4 secondary alone stays full", {5'b0, core_en}, 8'h07);
    endtask

    task automatic t_no_commit_r6();
        @(negedge clk);
        core_ps0_n = 0; nb_ps0_n = 0; cmd_tfn = 1; cmd_core_sel = 1; cmd_nb_sel = 0;
        repeat (3) @(negedge clk);
        check("R6 core hold", {2'b0, core_mode}, {2'b0, CORE_FULL});
        check("R6 nb hold", {4'b0, nb_mode}, {4'b0, NB_FULL});
        check("R6 telem hold", {6'b0, telem_mode}, 8'h00);
    endtask

    task automatic t_telem();
        send(1, 1, 1, 1, 1, 0, 0);
        check("R8 voltage only", {6'b0, telem_mode}, 8'h01);
        send(1, 1, 1, 1, 1, 1, 1);
        check("R10 reserved keeps", {6'b0, telem_mode}, 8'h01);
        send(1, 1, 1, 1, 1, 1, 0);
        check("R9 disabled", {6'b0, telem_mode}, 8'h02);
        send(1, 1, 1, 1, 0, 0, 1);
        check("R11 tfn0 keeps", {6'b0, telem_mode}, 8'h02);
        send(1, 1, 1, 1, 1, 1, 1);
        check("R10 reserved keeps off", {6'b0, telem_mode}, 8'h02);
        send(1, 1, 1, 1, 1, 0, 1);
        check("R7 volt and current", {6'b0, telem_mode}, 8'h00);
        send(1, 1, 1, 1, 0, 1, 0);
        check("R11 tfn0 keeps vi", {6'b0, telem_mode}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_r1();
        t_shed_r2_r3();
        t_secondary_r4();
        t_no_commit_r6();
        t_telem();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule